// File: doc/BRIEF.md
# Dual-Channel DAC Serial Write Sequencer

This block sits on the host side of a two-channel current-output DAC that has a three-wire serial port and a separate load strobe. It takes one command at a time over a valid/ready handshake and turns it into a serial frame. The frame holds a 2-bit channel select followed by the conversion code. The block drives the active-low chip select, the serial clock, the serial data line and the active-low load strobe. All of them come from registers in a single system clock domain.

A command either writes a frame or commits. A frame write selects channel A (address 01), channel B (10) or both channels with one code (11). It then either pulses the load strobe as soon as chip select returns high, or leaves the strobe alone so that further writes can be batched. A commit command sends no frame and only pulses the strobe, so both channels change at the same moment. Every minimum setup time, hold time and pulse width of the serial port is a parameter counted in system-clock cycles, and the integrator rounds each value up from nanoseconds. `busy` covers the whole transaction, and `done` marks its end.

Top module: `dac_write_seq`

## Requirements
- R1: Out of reset, chip select and load strobe are high, the serial clock and serial data are low, `busy` and `done` are low and `cmd_ready` is high.
- R2: A write command produces exactly FRAME_W = CODE_W+2 rising serial-clock edges while chip select is low. The bits sampled on those edges are the 2-bit address (bit 1 first) followed by the code, most significant bit first.
- R3: While chip select is low, serial data changes only in the cycle where the serial clock falls, so it is stable across every rising edge and every high phase.
- R4: Chip select falls at least T_CSS cycles before the first rising edge. Every high phase lasts at least T_HIGH cycles and every low phase between bits at least T_LOW cycles. Chip select rises at least T_CSH cycles after the last rising edge, and the serial clock stays low whenever chip select is high.
- R5: A write with `cmd_defer` low pulses the load strobe low exactly once. The pulse starts in the cycle in which chip select rises, lasts at least T_LDW cycles and only occurs while chip select is high.
- R6: A write with `cmd_defer` high produces no load-strobe pulse.
- R7: A command with `cmd_commit` high produces no chip-select activity and exactly one load-strobe pulse of at least T_LDW cycles.
- R8: `cmd_ready` is high only while the sequencer is idle. A command presented while it is busy is not taken and causes no frame.
- R9: `busy` is high from the cycle chip select falls (or the strobe starts, for a commit) until the load strobe is back high. `done` is a one-cycle pulse in the first idle cycle after each command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_addr | input | 2 | Channel select: 01 A, 10 B, 11 both |
| cmd_code | input | CODE_W | Conversion code |
| cmd_defer | input | 1 | Hold the load strobe after the write |
| cmd_commit | input | 1 | Pulse the load strobe only, no frame |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_sclk | output | 1 | Serial clock, idle low |
| dac_sdi | output | 1 | Serial data |
| dac_ld_n | output | 1 | Active-low load strobe |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CODE_W = 16, T_CSS = 2, T_HIGH = 3, T_LOW = 2, T_CSH = 4 and T_LDW = 3. Every spacing minimum therefore differs from its neighbours, and a counter loaded with the wrong parameter shows up as a too-short phase. Because T_LOW is below T_HIGH, a swap of the two phase lengths breaks a minimum. A T_CSS above one makes an early first rising edge visible. The default 16-bit code gives the full 18-edge frame, with the address bits and the all-ones and all-zero codes at the frame boundaries.

// File: rtl/dac_write_seq.sv
`timescale 1ns/1ps
module dac_write_seq #(
  parameter int CODE_W = 16,
  parameter int T_CSS  = 1,
  parameter int T_HIGH = 3,
  parameter int T_LOW  = 3,
  parameter int T_CSH  = 3,
  parameter int T_LDW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_addr,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_defer,
  input  logic              cmd_commit,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic              dac_ld_n,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = CODE_W + 2;
  localparam int T_A     = (T_CSS > T_HIGH) ? T_CSS : T_HIGH;
  localparam int T_B     = (T_LOW > T_CSH) ? T_LOW : T_CSH;
  localparam int T_C     = (T_A > T_B) ? T_A : T_B;
  localparam int T_MAX   = (T_C > T_LDW) ? T_C : T_LDW;
  localparam int CW      = $clog2(T_MAX + 1);
  localparam int BW      = $clog2(FRAME_W);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HIGH, S_LOW, S_TAIL, S_STROBE} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bits_left;
  logic [FRAME_W-1:0] shreg;
  logic              defer_q;

  assign cmd_ready = (st == S_IDLE);
  assign busy      = ~cmd_ready;
  wire   cnt_end   = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bits_left <= '0;
      shreg     <= '0;
      defer_q   <= 1'b0;
      dac_cs_n  <= 1'b1;
      dac_sclk  <= 1'b0;
      dac_sdi   <= 1'b0;
      dac_ld_n  <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            if (cmd_commit) begin
              dac_ld_n <= 1'b0;
              cnt      <= CW'(T_LDW - 1);
              st       <= S_STROBE;
            end else begin
              shreg     <= {cmd_addr, cmd_code};
              dac_sdi   <= cmd_addr[1];
              defer_q   <= cmd_defer;
              bits_left <= BW'(FRAME_W - 1);
              dac_cs_n  <= 1'b0;
              cnt       <= CW'(T_CSS - 1);
              st        <= S_SETUP;
            end
          end
        end
        S_SETUP, S_LOW: begin
          if (cnt_end) begin
            dac_sclk <= 1'b1;
            cnt      <= CW'(T_HIGH - 1);
            st       <= S_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HIGH: begin
          if (cnt_end) begin
            dac_sclk <= 1'b0;
            if (bits_left == '0) begin
              cnt <= CW'(T_CSH - 1);
              st  <= S_TAIL;
            end else begin
              dac_sdi   <= shreg[FRAME_W-2];
              shreg     <= shreg << 1;
              bits_left <= bits_left - 1'b1;
              cnt       <= CW'(T_LOW - 1);
              st        <= S_LOW;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_TAIL: begin
          if (cnt_end) begin
            dac_cs_n <= 1'b1;
            dac_sdi  <= 1'b0;
            if (defer_q) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              dac_ld_n <= 1'b0;
              cnt      <= CW'(T_LDW - 1);
              st       <= S_STROBE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_STROBE: begin
          if (cnt_end) begin
            dac_ld_n <= 1'b1;
            done     <= 1'b1;
            st       <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_write_seq_chk.sv
`timescale 1ns/1ps
module dac_write_seq_chk #(
  parameter int FRAME_W = 18
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic dac_cs_n,
  input logic dac_sclk,
  input logic dac_sdi,
  input logic dac_ld_n,
  input logic busy,
  input logic done
);
  logic [7:0] rise_cnt;
  logic       sclk_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      sclk_d   <= 1'b0;
      cs_d     <= 1'b1;
    end else begin
      sclk_d <= dac_sclk;
      cs_d   <= dac_cs_n;
      if (!dac_cs_n && cs_d) rise_cnt <= '0;
      else if (dac_sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  a_r2_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> (rise_cnt == 8'(FRAME_W)));
  a_r3_sdi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sclk |-> $stable(dac_sdi));
  a_r3_sdi_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n && $past(!dac_cs_n) && !$stable(dac_sdi)) |-> $fell(dac_sclk));
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> !dac_sclk);
  a_r5_strobe_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ld_n |-> dac_cs_n);
  a_r8_accept_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_cs_n) |-> $past(cmd_valid && cmd_ready));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && dac_cs_n && dac_ld_n));
  a_r9_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n || !dac_ld_n) |-> busy);
endmodule

bind dac_write_seq dac_write_seq_chk #(.FRAME_W(CODE_W + 2)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
  .dac_ld_n(dac_ld_n), .busy(busy), .done(done)
);

// File: tb/dac_write_seq_tb_top.sv
`timescale 1ns/1ps
module dac_write_seq_tb_top;
  localparam int CODE_W = 16;
  localparam int FW     = CODE_W + 2;
  localparam int T_CSS  = 2;
  localparam int T_HIGH = 3;
  localparam int T_LOW  = 2;
  localparam int T_CSH  = 4;
  localparam int T_LDW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_defer = 1'b0, cmd_commit = 1'b0;
  logic [1:0] cmd_addr = '0;
  logic [CODE_W-1:0] cmd_code = '0;
  logic cmd_ready, dac_cs_n, dac_sclk, dac_sdi, dac_ld_n, busy, done;

  always #2 clk = ~clk;

  dac_write_seq #(.CODE_W(CODE_W), .T_CSS(T_CSS), .T_HIGH(T_HIGH), .T_LOW(T_LOW),
                  .T_CSH(T_CSH), .T_LDW(T_LDW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_code(cmd_code), .cmd_defer(cmd_defer),
    .cmd_commit(cmd_commit), .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk),
    .dac_sdi(dac_sdi), .dac_ld_n(dac_ld_n), .busy(busy), .done(done));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // port monitor
  int cyc = 0, frames_started = 0, frames_done = 0, ld_pulses = 0, done_cnt = 0;
  int nrise = 0, last_nrise = 0;
  int t_csfall = 0, t_rise = 0, t_fall = 0, t_ldfall = 0;
  int v_sdi = 0, v_idle = 0, v_css = 0, v_high = 0, v_low = 0, v_csh = 0;
  int v_ldw = 0, v_ldcs = 0, v_busy = 0, v_done = 0;
  logic [FW-1:0] fbits = '0, last_frame = '0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_sdi = 1'b0, p_ld = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_cs && !dac_cs_n) begin
        frames_started++;
        t_csfall = cyc; nrise = 0; fbits = '0;
        if (!busy) v_busy++;
      end
      if (dac_cs_n && dac_sclk) v_idle++;
      if (!dac_cs_n && !p_cs && dac_sdi != p_sdi && !(p_sclk && !dac_sclk)) v_sdi++;
      if (!dac_cs_n && dac_sclk && !p_sclk) begin
        if (nrise == 0) begin
          if (cyc - t_csfall < T_CSS) v_css++;
        end else if (cyc - t_fall < T_LOW) v_low++;
        nrise++; fbits = {fbits[FW-2:0], dac_sdi}; t_rise = cyc;
      end
      if (!dac_sclk && p_sclk) begin
        if (cyc - t_rise < T_HIGH) v_high++;
        t_fall = cyc;
      end
      if (dac_cs_n && !p_cs) begin
        frames_done++; last_frame = fbits; last_nrise = nrise;
        if (cyc - t_rise < T_CSH) v_csh++;
      end
      if (!dac_ld_n && p_ld) begin
        ld_pulses++; t_ldfall = cyc;
        if (!dac_cs_n) v_ldcs++;
        if (!busy) v_busy++;
      end
      if (dac_ld_n && !p_ld && (cyc - t_ldfall < T_LDW)) v_ldw++;
      if (done) begin
        done_cnt++;
        if (busy) v_done++;
      end
    end
    p_cs = dac_cs_n; p_sclk = dac_sclk; p_sdi = dac_sdi; p_ld = dac_ld_n;
  end

  task automatic issue(input logic [1:0] a, input logic [CODE_W-1:0] c,
                       input logic dfr, input logic cmt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_code = c; cmd_defer = dfr; cmd_commit = cmt;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_commit = 1'b0; cmd_defer = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(dac_cs_n && dac_ld_n && !dac_sclk && !dac_sdi, "R1", "serial pins after reset",
        {dac_cs_n, dac_ld_n, dac_sclk, dac_sdi}, 4'b1100);
    chk(!busy && !done && cmd_ready, "R1", "busy/done/ready after reset",
        {busy, done, cmd_ready}, 3'b001);
  endtask

  task automatic t_immediate(input logic [1:0] a, input logic [CODE_W-1:0] c);
    int f0 = frames_done, l0 = ld_pulses, d0 = done_cnt;
    issue(a, c, 1'b0, 1'b0);
    chk(busy && !cmd_ready, "R9", "busy during frame", busy, 1);
    wait_done();
    chk(frames_done == f0 + 1, "R2", "one frame", frames_done - f0, 1);
    chk(last_nrise == FW, "R2", "rising edges per frame", last_nrise, FW);
    chk(last_frame == {a, c}, "R2", "frame bits", last_frame, {a, c});
    chk(ld_pulses == l0 + 1, "R5", "strobe pulses in immediate mode", ld_pulses - l0, 1);
    chk(done_cnt == d0 + 1 && !busy && cmd_ready, "R9", "done and idle",
        done_cnt - d0, 1);
    @(negedge clk);
    chk(!done, "R9", "done lasts one cycle", done, 0);
  endtask

  task automatic t_batch();
    int f0 = frames_done, l0 = ld_pulses, s0;
    issue(2'b01, 16'h1234, 1'b1, 1'b0);
    wait_done();
    chk(last_frame == {2'b01, 16'h1234}, "R2", "channel A frame", last_frame, {2'b01, 16'h1234});
    issue(2'b10, 16'hFEDC, 1'b1, 1'b0);
    wait_done();
    chk(last_frame == {2'b10, 16'hFEDC}, "R2", "channel B frame", last_frame, {2'b10, 16'hFEDC});
    chk(frames_done == f0 + 2, "R6", "two deferred frames", frames_done - f0, 2);
    chk(ld_pulses == l0 && dac_ld_n, "R6", "no strobe while deferred", ld_pulses - l0, 0);
    s0 = frames_started;
    issue(2'b00, 16'h0000, 1'b0, 1'b1);
    chk(busy, "R9", "busy during commit strobe", busy, 1);
    wait_done();
    chk(frames_started == s0, "R7", "commit sends no frame", frames_started - s0, 0);
    chk(ld_pulses == l0 + 1, "R7", "commit strobe pulses", ld_pulses - l0, 1);
  endtask

  task automatic t_busy_ignore();
    int s0 = frames_started;
    issue(2'b01, 16'h0F0F, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(busy && !cmd_ready, "R8", "not ready while busy", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_addr = 2'b10; cmd_code = 16'h7777;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    repeat (60) @(negedge clk);
    #1;
    chk(frames_started == s0 + 1, "R8", "command while busy not taken",
        frames_started - s0, 1);
    chk(last_frame == {2'b01, 16'h0F0F}, "R8", "frame unchanged by ignored command",
        last_frame, {2'b01, 16'h0F0F});
  endtask

  task automatic t_rules();
    chk(v_sdi == 0, "R3", "data moves off falling edge", v_sdi, 0);
    chk(v_idle == 0, "R4", "clock active with chip select high", v_idle, 0);
    chk(v_css == 0, "R4", "chip select setup short", v_css, 0);
    chk(v_high == 0, "R4", "clock high phase short", v_high, 0);
    chk(v_low == 0, "R4", "clock low phase short", v_low, 0);
    chk(v_csh == 0, "R4", "chip select hold short", v_csh, 0);
    chk(v_ldw == 0, "R5", "strobe pulse short", v_ldw, 0);
    chk(v_ldcs == 0, "R5", "strobe with chip select low", v_ldcs, 0);
    chk(v_busy == 0, "R9", "busy low at frame or strobe start", v_busy, 0);
    chk(v_done == 0, "R9", "done while busy", v_done, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_immediate(2'b01, 16'hA5C3);
    t_immediate(2'b10, 16'h0000);
    t_immediate(2'b11, 16'hFFFF);
    t_batch();
    t_busy_ignore();
    t_rules();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule